// File: doc/BRIEF.md
# Autoranging Rectifier Power Sequencer

This block is the control state machine of an AC-to-DC power front end. It receives periodic digital codes of the DC bus voltage. It decides when the bus has stopped charging by watching the change between consecutive samples. When the bus settles low, the block closes the voltage-doubler strap and waits for the bus to settle a second time. When the bus settles high, the block closes the switch that bypasses the inrush-limiting thermistor. Two timed stages follow: first the downstream converters are enabled, then a bus-good status is raised.

On loss of input power the bus decays. The status is dropped at a higher threshold and the converter enable at a lower one. A dip that stays above the disable threshold does not restart the sequence. A fall below it opens every switch, and the full power-up runs again when power returns. Voltage thresholds are parameters in sample codes. The two delays are counted in milliseconds from a prescaler derived from the clock-frequency parameter.

Top module: `pwrseq_top`

## Requirements
- R1: While reset is held and in the cycle after it, strap_on, bypass_on, conv_en and bus_good are all 0.
- R2: The bus counts as settled once SETTLE_N consecutive valid samples each differ from the sample before them by strictly less than DELTA codes. A difference equal to DELTA breaks the run. The settle takes effect on the outputs one cycle after the edge that registers the last qualifying sample.
- R3: A settle whose code is below DBL_TH, with the strap open, closes the strap and leaves the bypass open. The detector then needs a fresh run of SETTLE_N samples. The strap is not closed when the settle code is DBL_TH or above, and once closed it stays closed until a disable.
- R4: A settle whose code is above BYP_TH closes the bypass. A settle at BYP_TH or below, with no strap action due, leaves all outputs unchanged.
- R5: conv_en rises exactly DELAY_MS*CLK_HZ/1000 clock cycles after bypass_on rises.
- R6: bus_good rises exactly DELAY_MS*CLK_HZ/1000 clock cycles after conv_en rises, provided the latest sample is at or above OK_TH.
- R7: While running, a sample below OK_TH clears bus_good one cycle after it is registered. A later sample at or above OK_TH sets bus_good again.
- R8: With the bypass closed, a sample below DIS_TH clears all four outputs one cycle after it is registered and restarts the power-up. This takes priority over a delay expiry in the same cycle.
- R9: A sample between DIS_TH and OK_TH leaves conv_en and bypass_on set, and the sequence is not repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A new bus-voltage code is present this cycle |
| smp_code | input | W | Bus-voltage sample code |
| strap_on | output | 1 | Voltage-doubler strap closed |
| bypass_on | output | 1 | Inrush thermistor bypass closed |
| conv_en | output | 1 | Downstream converter enable |
| bus_good | output | 1 | Bus status good |

## Verification
Two functions can fall in the same cycle: the delay timer expiring and the disable comparator seeing a sample below DIS_TH. The bench measures the cycle in which the bypass closes. It then places a low sample so that it is registered on exactly the edge where the enable delay ends. The expected result is that conv_en never rises and the bypass reopens, which shows the disable wins. A second overlap is also checked: a settle arriving while the strap is already closed must not be taken as a second doubler event.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    ST_CHARGE  = 2'd0,
    ST_WAIT_EN = 2'd1,
    ST_WAIT_OK = 2'd2,
    ST_RUN     = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pwrseq_slope.sv
// Flags a settled bus after SETTLE_N small consecutive steps.
module pwrseq_slope #(
  parameter int W        = 10,
  parameter int DELTA    = 4,
  parameter int SETTLE_N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_code,
  input  logic         rearm,
  output logic         settled,
  output logic [W-1:0] settled_code
);
  localparam int CW = $clog2(SETTLE_N + 1);

  logic [W-1:0]  prev;
  logic          have_prev;
  logic [CW-1:0] cnt;
  logic [W-1:0]  diff;

  always_comb begin
    diff = (smp_code >= prev) ? (smp_code - prev) : (prev - smp_code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev         <= '0;
      have_prev    <= 1'b0;
      cnt          <= '0;
      settled      <= 1'b0;
      settled_code <= '0;
    end else begin
      settled <= 1'b0;
      if (rearm) begin
        cnt <= '0;
      end else if (smp_valid) begin
        prev      <= smp_code;
        have_prev <= 1'b1;
        if (have_prev && (diff < W'(DELTA))) begin
          if (cnt == CW'(SETTLE_N - 1)) begin
            cnt          <= '0;
            settled      <= 1'b1;
            settled_code <= smp_code;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pwrseq_delay.sv
// Millisecond delay: prescaler plus millisecond counter.
module pwrseq_delay #(
  parameter int CLKS_PER_MS = 100000,
  parameter int DELAY_MS    = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic done
);
  localparam int PW = $clog2(CLKS_PER_MS + 1);
  localparam int MW = $clog2(DELAY_MS + 1);

  logic [PW-1:0] pre;
  logic [MW-1:0] ms;
  logic          pre_wrap;

  always_comb begin
    pre_wrap = (pre == PW'(CLKS_PER_MS - 1));
    done     = run && pre_wrap && (ms == MW'(DELAY_MS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      pre <= '0;
      ms  <= '0;
    end else if (pre_wrap) begin
      pre <= '0;
      ms  <= ms + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int W        = 10,
  parameter int CLK_HZ   = 100000000,
  parameter int DELAY_MS = 50,
  parameter int DELTA    = 4,
  parameter int SETTLE_N = 8,
  parameter int DBL_TH   = 200,
  parameter int BYP_TH   = 235,
  parameter int OK_TH    = 205,
  parameter int DIS_TH   = 200
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_code,
  output logic         strap_on,
  output logic         bypass_on,
  output logic         conv_en,
  output logic         bus_good
);
  localparam int CLKS_PER_MS = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;

  seq_state_e   st, st_n;
  logic         strap_n, bypass_n, conv_n, good_n;
  logic         ok_lvl, ok_lvl_n;
  logic         lo_dis;
  logic         rearm, restart, run, done;
  logic         settled;
  logic [W-1:0] settled_code;

  pwrseq_slope #(.W(W), .DELTA(DELTA), .SETTLE_N(SETTLE_N)) u_slope (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_code(smp_code),
    .rearm(rearm), .settled(settled), .settled_code(settled_code)
  );

  pwrseq_delay #(.CLKS_PER_MS(CLKS_PER_MS), .DELAY_MS(DELAY_MS)) u_delay (
    .clk(clk), .rst(rst), .run(run), .restart(restart), .done(done)
  );

  always_comb begin
    lo_dis   = smp_valid && (smp_code < W'(DIS_TH));
    ok_lvl_n = smp_valid ? (smp_code >= W'(OK_TH)) : ok_lvl;
    run      = (st == ST_WAIT_EN) || (st == ST_WAIT_OK);
  end

  always_comb begin
    st_n     = st;
    strap_n  = strap_on;
    bypass_n = bypass_on;
    conv_n   = conv_en;
    good_n   = bus_good;
    rearm    = 1'b0;
    if (st != ST_CHARGE && lo_dis) begin
      // disable wins over any timer event in the same cycle
      st_n     = ST_CHARGE;
      strap_n  = 1'b0;
      bypass_n = 1'b0;
      conv_n   = 1'b0;
      good_n   = 1'b0;
      rearm    = 1'b1;
    end else begin
      case (st)
        ST_CHARGE: begin
          if (settled) begin
            if (settled_code > W'(BYP_TH)) begin
              bypass_n = 1'b1;
              st_n     = ST_WAIT_EN;
            end else if (settled_code < W'(DBL_TH) && !strap_on) begin
              strap_n = 1'b1;
            end
          end
        end
        ST_WAIT_EN: begin
          if (done) begin
            conv_n = 1'b1;
            st_n   = ST_WAIT_OK;
          end
        end
        ST_WAIT_OK: begin
          if (done) begin
            good_n = ok_lvl_n;
            st_n   = ST_RUN;
          end
        end
        default: good_n = ok_lvl_n;
      endcase
    end
    restart = (st_n != st);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_CHARGE;
      strap_on  <= 1'b0;
      bypass_on <= 1'b0;
      conv_en   <= 1'b0;
      bus_good  <= 1'b0;
      ok_lvl    <= 1'b0;
    end else begin
      st        <= st_n;
      strap_on  <= strap_n;
      bypass_on <= bypass_n;
      conv_en   <= conv_n;
      bus_good  <= good_n;
      ok_lvl    <= ok_lvl_n;
    end
  end
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int W      = 10,
  parameter int OK_TH  = 205,
  parameter int DIS_TH = 200
) (
  input logic         clk,
  input logic         rst,
  input logic         smp_valid,
  input logic [W-1:0] smp_code,
  input logic         strap_on,
  input logic         bypass_on,
  input logic         conv_en,
  input logic         bus_good
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!strap_on && !bypass_on && !conv_en && !bus_good));

  assert_bypass_rise_idle_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(bypass_on) |-> !conv_en);

  assert_enable_after_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_en) |-> $past(bypass_on));

  assert_enable_needs_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    conv_en |-> bypass_on);

  assert_good_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
    bus_good |-> conv_en);

  assert_good_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_code < W'(OK_TH) && bus_good) |=> !bus_good);

  assert_disable_R8: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_code < W'(DIS_TH) && bypass_on) |=>
      (!conv_en && !bypass_on && !strap_on));

  assert_dip_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_code >= W'(DIS_TH) && conv_en) |=> conv_en);
endmodule

bind pwrseq_top pwrseq_chk #(.W(W), .OK_TH(OK_TH), .DIS_TH(DIS_TH)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_code(smp_code),
  .strap_on(strap_on), .bypass_on(bypass_on), .conv_en(conv_en),
  .bus_good(bus_good)
);

// File: tb/tb_pwrseq_top.sv
`timescale 1ns/1ps
module tb_pwrseq_top;
  localparam int W        = 10;
  localparam int CLK_HZ   = 4000;
  localparam int DELAY_MS = 3;
  localparam int STEP     = DELAY_MS * (CLK_HZ / 1000);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         smp_valid = 1'b0;
  logic [W-1:0] smp_code = '0;
  logic         strap_on, bypass_on, conv_en, bus_good;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pwrseq_top #(.W(W), .CLK_HZ(CLK_HZ), .DELAY_MS(DELAY_MS), .DELTA(4),
               .SETTLE_N(3), .DBL_TH(200), .BYP_TH(235), .OK_TH(205),
               .DIS_TH(200)) dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_code(smp_code),
    .strap_on(strap_on), .bypass_on(bypass_on), .conv_en(conv_en),
    .bus_good(bus_good)
  );

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // returns at the negedge after the edge that registered the sample
  task automatic send(int code);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_code  = W'(code);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check("R1", "strap during reset", strap_on, 1'b0);
    check("R1", "bypass during reset", bypass_on, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "conv_en after reset", conv_en, 1'b0);
    check("R1", "bus_good after reset", bus_good, 1'b0);
  endtask

  task automatic test_doubler_path();
    send(150); send(154); send(155); send(156);
    @(negedge clk);
    check("R2", "diff equal to delta breaks run", strap_on, 1'b0);
    send(157);
    @(negedge clk);
    check("R3", "strap closes on low settle", strap_on, 1'b1);
    check("R3", "bypass open after doubler", bypass_on, 1'b0);
    send(190); send(191); send(192); send(193);
    @(negedge clk);
    check("R3", "second low settle keeps state", strap_on, 1'b1);
    check("R3", "second low settle no bypass", bypass_on, 1'b0);
    send(260); send(300); send(301); send(302); send(303);
    @(negedge clk);
    check("R4", "bypass closes on high settle", bypass_on, 1'b1);
    check("R3", "strap held with bypass", strap_on, 1'b1);
    repeat (STEP - 1) @(negedge clk);
    check("R5", "conv_en one cycle early", conv_en, 1'b0);
    @(negedge clk);
    check("R5", "conv_en on time", conv_en, 1'b1);
    repeat (STEP - 1) @(negedge clk);
    check("R6", "bus_good one cycle early", bus_good, 1'b0);
    @(negedge clk);
    check("R6", "bus_good on time", bus_good, 1'b1);
  endtask

  task automatic test_powerdown();
    send(204);
    check("R7", "bus_good drops below ok level", bus_good, 1'b0);
    check("R9", "conv_en holds in dip", conv_en, 1'b1);
    send(210);
    check("R7", "bus_good returns", bus_good, 1'b1);
    send(201);
    check("R9", "conv_en holds above disable", conv_en, 1'b1);
    check("R9", "bypass holds above disable", bypass_on, 1'b1);
    send(198);
    check("R8", "conv_en cleared", conv_en, 1'b0);
    check("R8", "bypass reopened", bypass_on, 1'b0);
    check("R8", "strap reopened", strap_on, 1'b0);
    check("R8", "bus_good cleared", bus_good, 1'b0);
  endtask

  task automatic test_mid_and_race();
    send(220); send(221); send(222); send(223);
    @(negedge clk);
    check("R4", "mid settle leaves bypass open", bypass_on, 1'b0);
    check("R3", "mid settle no doubler", strap_on, 1'b0);
    send(236); send(237); send(238); send(239);
    @(negedge clk);
    check("R4", "bypass closes without doubler", bypass_on, 1'b1);
    check("R3", "strap stays open at high level", strap_on, 1'b0);
    repeat (STEP - 1) @(negedge clk);
    smp_valid = 1'b1;
    smp_code  = W'(150);
    @(negedge clk);
    smp_valid = 1'b0;
    check("R8", "disable beats delay expiry conv_en", conv_en, 1'b0);
    check("R8", "disable beats delay expiry bypass", bypass_on, 1'b0);
    repeat (STEP + 2) @(negedge clk);
    check("R8", "no late enable after restart", conv_en, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    test_reset();
    test_doubler_path();
    test_powerdown();
    test_mid_and_race();
    finish_run();
  end
endmodule